// File: doc/BRIEF.md
# Serial Channel FIFO Control and DMA Ready Logic

This block holds the queueing and DMA-request side of one serial channel. It contains a 32-entry receive byte queue and a 32-entry transmit byte queue, both with plain push and pop ports, and an 8-bit control register. The register turns the queues on or off, clears either queue through a bit that drops back to 0 by itself, picks the receive and transmit trigger levels, and selects the DMA signalling style.

Two active-low ready outputs tell a DMA engine when to move data. In single-transfer style they follow the queue occupancy directly. In block style they latch: receive ready latches on a trigger level or a time-out and releases on empty; transmit ready latches on full and releases at its trigger level. Four external level inputs can override the coded trigger levels. The shift logic, baud timing and host bus sit outside this block.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control register reads 0x00, both counts are 0, `rx_ready_no` is 1 and `tx_ready_no` is 0.
- R2: With bit 0 set, each queue holds up to 32 bytes in first-in first-out order. A push to a full queue and a pop from an empty queue are ignored.
- R3: With bit 0 clear, each queue holds at most one byte.
- R4: Writing bit 1 as 1 empties the receive queue at the next clock edge. Bit 1 reads 1 for that one cycle and then reads 0. The transmit queue is unchanged.
- R5: Bit 2 clears the transmit queue in the same way, and leaves the receive queue unchanged.
- R6: Receive trigger code in bits 7:6: 00 gives 8 bytes, 01 gives 16, 10 gives 24 and 11 gives 28.
- R7: Transmit trigger code in bits 5:4: 00 gives 16 bytes, 01 gives 8, 10 gives 24 and 11 gives 30.
- R8: When any of `rx_lvl_i`, `tx_lvl_i`, `flow_hi_i` or `flow_lo_i` is nonzero, the trigger levels come from `rx_lvl_i` and `tx_lvl_i` instead of the codes.
- R9: Single-transfer style applies unless bits 0 and 3 are both 1. In that style, one cycle after a count change, `rx_ready_no` is 0 exactly when the receive count is at least 1, and `tx_ready_no` is 0 exactly when the transmit count is 0.
- R10: In block style, `rx_ready_no` goes to 0 one cycle after the receive count reaches or exceeds the trigger level, or in the cycle after `rx_timeout_i` is high. It then holds 0 until the count is 0, when it goes to 1.
- R11: In block style, `tx_ready_no` goes to 1 one cycle after the transmit queue is full. It goes to 0 one cycle after the count is at or below the trigger level, and it holds its value in between.
- R12: A queue clear forces the matching ready output to its reset value at the same edge that empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_we_i | input | 1 | Control register write strobe |
| fcr_wdata_i | input | 8 | Control register write data |
| fcr_o | output | 8 | Control register read value |
| rx_lvl_i | input | 8 | Custom receive trigger level |
| tx_lvl_i | input | 8 | Custom transmit trigger level |
| flow_hi_i | input | 8 | Custom flow high level (only used for override detect) |
| flow_lo_i | input | 8 | Custom flow low level (only used for override detect) |
| rx_push_i | input | 1 | Receive queue push |
| rx_data_i | input | 8 | Receive push data |
| rx_pop_i | input | 1 | Receive queue pop |
| rx_data_o | output | 8 | Receive queue head byte |
| rx_count_o | output | 6 | Receive occupancy |
| rx_full_o | output | 1 | Receive queue full |
| tx_push_i | input | 1 | Transmit queue push |
| tx_data_i | input | 8 | Transmit push data |
| tx_pop_i | input | 1 | Transmit queue pop |
| tx_data_o | output | 8 | Transmit queue head byte |
| tx_count_o | output | 6 | Transmit occupancy |
| tx_full_o | output | 1 | Transmit queue full |
| rx_timeout_i | input | 1 | Receive time-out pulse |
| rx_ready_no | output | 1 | Receive DMA ready, active low |
| tx_ready_no | output | 1 | Transmit DMA ready, active low |

## Verification
The hardest state to reach is the transmit hysteresis band in block style. The queue must first be filled to exactly 32 so that the output latches high. It must then be drained one byte at a time to one above the coded level, and then to the level itself. After that the bench pushes one byte back, to show that the output stays low. The bench repeats this walk for every transmit code, including the non-monotonic 00/01 pair. The receive side is driven the same way: one byte short of the level, then the level, then a drain to a single byte and on to empty.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       blk_mode;
    logic       tx_clr;
    logic       rx_clr;
    logic       en;
  } fcr_t;

  function automatic logic [7:0] rx_code_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd8;
      2'b01:   return 8'd16;
      2'b10:   return 8'd24;
      default: return 8'd28;
    endcase
  endfunction

  // deliberately non-monotonic code order
  function automatic logic [7:0] tx_code_lvl(input logic [1:0] code);
    case (code)
      2'b00:   return 8'd16;
      2'b01:   return 8'd8;
      2'b10:   return 8'd24;
      default: return 8'd30;
    endcase
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  // disabled queue behaves as a single holding byte
  assign full_o  = en_i ? (cnt == CW'(DEPTH)) : (cnt != '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && (cnt != '0) && !clr_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  assign data_o  = mem[rd_ptr];
  assign count_o = cnt;

endmodule

// File: rtl/trig_sel.sv
module trig_sel
  import uart_fifo_ctl_pkg::*;
#(
  parameter int CW = 6,
  parameter int LW = 8,
  localparam int XW = ((CW > LW) ? CW : LW) + 1
) (
  input  logic [1:0]    rx_code_i,
  input  logic [1:0]    tx_code_i,
  input  logic [LW-1:0] rx_lvl_i,
  input  logic [LW-1:0] tx_lvl_i,
  input  logic [LW-1:0] flow_hi_i,
  input  logic [LW-1:0] flow_lo_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  output logic          rx_reach_o,
  output logic          tx_drain_o
);

  logic          custom;
  logic [XW-1:0] rx_trig, tx_trig;

  assign custom  = |{rx_lvl_i, tx_lvl_i, flow_hi_i, flow_lo_i};
  assign rx_trig = custom ? XW'(rx_lvl_i) : XW'(rx_code_lvl(rx_code_i));
  assign tx_trig = custom ? XW'(tx_lvl_i) : XW'(tx_code_lvl(tx_code_i));

  assign rx_reach_o = XW'(rx_count_i) >= rx_trig;
  assign tx_drain_o = XW'(tx_count_i) <= tx_trig;

endmodule

// File: rtl/dma_ready.sv
module dma_ready #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic block_i,
  input  logic clr_i,
  input  logic single_hi_i,
  input  logic hi_i,
  input  logic lo_i,
  output logic rdy_no
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdy_no <= RST_VAL;
    else if (clr_i)    rdy_no <= RST_VAL;
    else if (!block_i) rdy_no <= single_hi_i;
    else if (hi_i)     rdy_no <= 1'b1;
    else if (lo_i)     rdy_no <= 1'b0;
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  parameter int LW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_wdata_i,
  output logic [7:0]    fcr_o,
  input  logic [LW-1:0] rx_lvl_i,
  input  logic [LW-1:0] tx_lvl_i,
  input  logic [LW-1:0] flow_hi_i,
  input  logic [LW-1:0] flow_lo_i,
  input  logic          rx_push_i,
  input  logic [W-1:0]  rx_data_i,
  input  logic          rx_pop_i,
  output logic [W-1:0]  rx_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic          rx_full_o,
  input  logic          tx_push_i,
  input  logic [W-1:0]  tx_data_i,
  input  logic          tx_pop_i,
  output logic [W-1:0]  tx_data_o,
  output logic [CW-1:0] tx_count_o,
  output logic          tx_full_o,
  input  logic          rx_timeout_i,
  output logic          rx_ready_no,
  output logic          tx_ready_no
);

  fcr_t fcr_q;
  logic blk, rx_reach, tx_drain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcr_q <= '0;
    end else if (fcr_we_i) begin
      fcr_q <= fcr_t'(fcr_wdata_i);
    end else begin
      fcr_q.rx_clr <= 1'b0;
      fcr_q.tx_clr <= 1'b0;
    end
  end

  assign fcr_o = fcr_q;
  assign blk   = fcr_q.en && fcr_q.blk_mode;

  byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clr_i(fcr_q.rx_clr), .en_i(fcr_q.en),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .count_o(rx_count_o), .full_o(rx_full_o)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(W)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clr_i(fcr_q.tx_clr), .en_i(fcr_q.en),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .count_o(tx_count_o), .full_o(tx_full_o)
  );

  trig_sel #(.CW(CW), .LW(LW)) u_trig (
    .rx_code_i(fcr_q.rx_code), .tx_code_i(fcr_q.tx_code),
    .rx_lvl_i, .tx_lvl_i, .flow_hi_i, .flow_lo_i,
    .rx_count_i(rx_count_o), .tx_count_i(tx_count_o),
    .rx_reach_o(rx_reach), .tx_drain_o(tx_drain)
  );

  // channel 0 = receive, channel 1 = transmit
  logic [1:0] clr_v, single_hi_v, hi_v, lo_v, rdy_v;

  assign clr_v       = {fcr_q.tx_clr, fcr_q.rx_clr};
  assign single_hi_v = {tx_count_o != '0, rx_count_o == '0};
  assign hi_v        = {tx_full_o, rx_count_o == '0};
  assign lo_v        = {tx_drain, rx_reach || rx_timeout_i};

  for (genvar ch = 0; ch < 2; ch++) begin : g_rdy
    dma_ready #(.RST_VAL(ch == 0)) u_rdy (
      .clk_i, .rst_ni,
      .block_i(blk), .clr_i(clr_v[ch]),
      .single_hi_i(single_hi_v[ch]), .hi_i(hi_v[ch]), .lo_i(lo_v[ch]),
      .rdy_no(rdy_v[ch])
    );
  end

  assign rx_ready_no = rdy_v[0];
  assign tx_ready_no = rdy_v[1];

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fcr_we_i,
  input logic [7:0]    fcr_o,
  input logic [CW-1:0] rx_count_o,
  input logic [CW-1:0] tx_count_o,
  input logic          rx_ready_no,
  input logic          tx_ready_no
);

  logic blk;
  assign blk = fcr_o[0] && fcr_o[3];

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o <= CW'(DEPTH) && tx_count_o <= CW'(DEPTH)); // R2
  AST_DIS_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fcr_o[0] && !fcr_we_i && rx_count_o != 0) |=> rx_count_o <= $past(rx_count_o)); // R3
  AST_RX_CLR_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcr_o[1] && !fcr_we_i) |=> !fcr_o[1]); // R4
  AST_RX_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_o[1] |=> rx_count_o == 0); // R4
  AST_TX_CLR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_o[2] |=> tx_count_o == 0); // R5
  AST_SINGLE_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk && !fcr_o[1]) |=> rx_ready_no == ($past(rx_count_o) == 0)); // R9
  AST_SINGLE_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blk && !fcr_o[2]) |=> tx_ready_no == ($past(tx_count_o) != 0)); // R9
  AST_BLK_RX_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk && rx_count_o == 0) |=> rx_ready_no); // R10
  AST_BLK_TX_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk && !fcr_o[2] && tx_count_o == CW'(DEPTH)) |=> tx_ready_no); // R11
  AST_RX_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_o[1] |=> rx_ready_no); // R12
  AST_TX_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_o[2] |=> !tx_ready_no); // R12

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fcr_we_i(fcr_we_i), .fcr_o(fcr_o),
  .rx_count_o(rx_count_o), .tx_count_o(tx_count_o),
  .rx_ready_no(rx_ready_no), .tx_ready_no(tx_ready_no)
);

// File: tb/uart_fifo_ctl_test.sv
module uart_fifo_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       fcr_we = 1'b0;
  logic [7:0] fcr_wdata = '0, fcr;
  logic [7:0] rx_lvl = '0, tx_lvl = '0, flow_hi = '0, flow_lo = '0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_din = '0, tx_din = '0, rx_dout, tx_dout;
  logic [5:0] rx_cnt, tx_cnt;
  logic       rx_full, tx_full, rx_to = 1'b0, rx_rdy_n, tx_rdy_n;
  int         total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_wdata), .fcr_o(fcr),
    .rx_lvl_i(rx_lvl), .tx_lvl_i(tx_lvl), .flow_hi_i(flow_hi), .flow_lo_i(flow_lo),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_count_o(rx_cnt), .rx_full_o(rx_full),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_count_o(tx_cnt), .tx_full_o(tx_full),
    .rx_timeout_i(rx_to), .rx_ready_no(rx_rdy_n), .tx_ready_no(tx_rdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    fcr_wdata = v; fcr_we = 1'b1;
    @(negedge clk);
    fcr_we = 1'b0;
  endtask

  task automatic rx_push_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      rx_din = 8'(base + i); rx_push = 1'b1;
      @(negedge clk);
    end
    rx_push = 1'b0;
  endtask

  task automatic rx_pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      rx_pop = 1'b1;
      @(negedge clk);
    end
    rx_pop = 1'b0;
  endtask

  task automatic tx_push_n(input int n);
    for (int i = 0; i < n; i++) begin
      tx_din = 8'(i); tx_push = 1'b1;
      @(negedge clk);
    end
    tx_push = 1'b0;
  endtask

  task automatic tx_pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      tx_pop = 1'b1;
      @(negedge clk);
    end
    tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk(fcr == 8'h00, "R1 fcr", fcr, 0);
    chk(rx_cnt == 0 && tx_cnt == 0, "R1 counts", rx_cnt + tx_cnt, 0);
    chk(rx_rdy_n == 1'b1, "R1 rx_ready", rx_rdy_n, 1);
    chk(tx_rdy_n == 1'b0, "R1 tx_ready", tx_rdy_n, 0);
  endtask

  task automatic t_order();
    wr_fcr(8'h07); settle();
    rx_push_n(33, 100);
    chk(rx_cnt == 32, "R2 count at capacity", rx_cnt, 32);
    chk(rx_full, "R2 full flag", rx_full, 1);
    for (int i = 0; i < 32; i++) begin
      chk(rx_dout == 8'(100 + i), "R2 order", rx_dout, 100 + i);
      rx_pop_n(1);
    end
    rx_pop_n(1);
    chk(rx_cnt == 0, "R2 pop when empty", rx_cnt, 0);
  endtask

  task automatic t_disabled();
    wr_fcr(8'h06); settle();
    rx_push_n(3, 0);
    chk(rx_cnt == 1, "R3 disabled capacity", rx_cnt, 1);
    rx_pop_n(1);
  endtask

  task automatic t_single();
    wr_fcr(8'h07); settle(); settle();
    chk(rx_rdy_n == 1'b1, "R9 rx idle empty", rx_rdy_n, 1);
    rx_push_n(1, 0); settle();
    chk(rx_rdy_n == 1'b0, "R9 rx one byte", rx_rdy_n, 0);
    chk(tx_rdy_n == 1'b0, "R9 tx empty", tx_rdy_n, 0);
    tx_push_n(1); settle();
    chk(tx_rdy_n == 1'b1, "R9 tx holds byte", tx_rdy_n, 1);
    rx_pop_n(1); tx_pop_n(1); settle();
    chk(rx_rdy_n == 1'b1 && tx_rdy_n == 1'b0, "R9 back to idle", {rx_rdy_n, tx_rdy_n}, 2);
  endtask

  task automatic t_rx_codes();
    for (int c = 0; c < 4; c++) begin
      int trig;
      trig = (c == 0) ? 8 : (c == 1) ? 16 : (c == 2) ? 24 : 28;
      wr_fcr(8'((c << 6) | 8'h0B)); settle();
      rx_push_n(trig - 1, 0); settle();
      chk(rx_rdy_n == 1'b1, "R6 below rx level", rx_rdy_n, 1);
      rx_push_n(1, 0); settle();
      chk(rx_rdy_n == 1'b0, "R6 at rx level", rx_rdy_n, 0);
      rx_pop_n(trig - 1); settle();
      chk(rx_rdy_n == 1'b0, "R10 held until empty", rx_rdy_n, 0);
      rx_pop_n(1); settle();
      chk(rx_rdy_n == 1'b1, "R10 released on empty", rx_rdy_n, 1);
    end
  endtask

  task automatic t_timeout();
    wr_fcr(8'h0B); settle();
    rx_push_n(1, 0); settle();
    chk(rx_rdy_n == 1'b1, "R10 one byte no timeout", rx_rdy_n, 1);
    rx_to = 1'b1; @(negedge clk); rx_to = 1'b0; settle();
    chk(rx_rdy_n == 1'b0, "R10 timeout asserts", rx_rdy_n, 0);
    rx_pop_n(1); settle();
    chk(rx_rdy_n == 1'b1, "R10 timeout release", rx_rdy_n, 1);
  endtask

  task automatic t_tx_codes();
    for (int c = 0; c < 4; c++) begin
      int trig;
      trig = (c == 0) ? 16 : (c == 1) ? 8 : (c == 2) ? 24 : 30;
      wr_fcr(8'((c << 4) | 8'h0D)); settle(); settle();
      chk(tx_rdy_n == 1'b0, "R11 tx empty low", tx_rdy_n, 0);
      tx_push_n(31); settle();
      chk(tx_rdy_n == 1'b0, "R11 below full holds low", tx_rdy_n, 0);
      tx_push_n(1); settle();
      chk(tx_rdy_n == 1'b1, "R11 full high", tx_rdy_n, 1);
      tx_pop_n(31 - trig); settle();
      chk(tx_rdy_n == 1'b1, "R7 above tx level holds", tx_rdy_n, 1);
      tx_pop_n(1); settle();
      chk(tx_rdy_n == 1'b0, "R7 at tx level low", tx_rdy_n, 0);
      tx_push_n(1); settle();
      chk(tx_rdy_n == 1'b0, "R11 hysteresis", tx_rdy_n, 0);
    end
  endtask

  task automatic t_custom();
    rx_lvl = 8'd5; tx_lvl = 8'd3;
    wr_fcr(8'h0F); settle();
    rx_push_n(4, 0); settle();
    chk(rx_rdy_n == 1'b1, "R8 custom rx below", rx_rdy_n, 1);
    rx_push_n(1, 0); settle();
    chk(rx_rdy_n == 1'b0, "R8 custom rx reached", rx_rdy_n, 0);
    tx_push_n(32); tx_pop_n(28); settle();
    chk(tx_rdy_n == 1'b1, "R8 custom tx above", tx_rdy_n, 1);
    tx_pop_n(1); settle();
    chk(tx_rdy_n == 1'b0, "R8 custom tx reached", tx_rdy_n, 0);
    rx_lvl = 8'd0; tx_lvl = 8'd0;
    flow_lo = 8'd1; rx_lvl = 8'd0;
    wr_fcr(8'h0B); settle();
    rx_push_n(1, 0); settle();
    chk(rx_rdy_n == 1'b0, "R8 flow reg selects custom rx 0", rx_rdy_n, 0);
    flow_lo = 8'd0;
  endtask

  task automatic t_clear();
    wr_fcr(8'h0F); settle();
    rx_push_n(10, 0); tx_push_n(32); settle();
    chk(rx_rdy_n == 1'b0 && tx_rdy_n == 1'b1, "R12 setup", {rx_rdy_n, tx_rdy_n}, 1);
    wr_fcr(8'h0B);
    chk(fcr[1] == 1'b1, "R4 clear bit visible", fcr[1], 1);
    settle();
    chk(fcr[1] == 1'b0, "R4 clear bit self-clears", fcr[1], 0);
    chk(rx_cnt == 0, "R4 rx emptied", rx_cnt, 0);
    chk(rx_rdy_n == 1'b1, "R12 rx forced idle", rx_rdy_n, 1);
    chk(tx_cnt == 32, "R4 tx untouched", tx_cnt, 32);
    rx_push_n(3, 0);
    wr_fcr(8'h0D); settle();
    chk(fcr[2] == 1'b0, "R5 clear bit self-clears", fcr[2], 0);
    chk(tx_cnt == 0, "R5 tx emptied", tx_cnt, 0);
    chk(tx_rdy_n == 1'b0, "R12 tx forced idle", tx_rdy_n, 0);
    chk(rx_cnt == 3, "R5 rx untouched", rx_cnt, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_order();
    t_disabled();
    t_single();
    t_rx_codes();
    t_timeout();
    t_tx_codes();
    t_custom();
    t_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule